// File: doc/BRIEF.md
# Command-driven I2C master controller

This block is a register-programmed I2C bus master for 7-bit addressing. Software drives it one micro-command at a time. A single write to the command register may ask for any mix of a START condition, one byte sent from the transmit register, one byte received into the receive register (with ACK or NACK), and a STOP condition. The block runs the requested phases in the fixed order START, byte, STOP. It raises the command-complete event when the last one has finished, then waits for the next command. It does not sequence a whole transfer by itself. To address a device, software writes the address shifted left by one, with the read/write flag in bit 0, into the transmit register, then issues START plus WRITE.

Bus timing comes from two counts, one for the SCL high phase and one for the low phase. A status register holds a bus-busy bit and seven sticky event flags. The flags are cleared by writing ones to a clear register. A mask in the control register gates them onto one interrupt line. SCL and SDA are open-drain: each output is an enable that pulls its line low, and each line is read back through an input. If another master pulls SDA low while this one is sending a 1, the loss is detected and flagged. Clock stretching is not honoured.

Registers are selected by a word index (byte offset divided by four): 0 control, 1 command, 2 flag clear, 3 status, 4 SCL high count, 5 SCL low count, 6 transmit byte, 7 receive byte. Reads are combinational. The command and clear registers read as zero.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the status word is 0, the control word reads 0, `irq` is low, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: Command bits are: bit 4 no-ACK, bit 3 START, bit 2 READ, bit 1 WRITE, bit 0 STOP. For START+WRITE (0x0A) on an idle bus, the block drives a START condition and then shifts the transmit byte out MSB first on eight SCL pulses, and samples the acknowledge on a ninth pulse. It then sets the status flags start (bit 6), send (bit 4) and command-over (bit 0), plus busy (bit 7). The address byte is the address shifted left by one with the read/write flag in bit 0.
- R3: When SDA is high at the ninth clock of a written byte, the ack-error flag (status bit 2) is set, and the command still completes with command-over set.
- R4: A READ (0x04) samples eight bits MSB first, loads them into the receive register and sets the receive flag (bit 3). The master pulls SDA low during the ninth clock (ACK).
- R5: A READ with the no-ACK bit (0x14) leaves SDA released during the ninth clock (NACK), and still stores the byte.
- R6: Busy (status bit 7) rises with a START condition and stays set across commands that carry no STOP. It clears only when a STOP has completed on the bus, at which point the end flag (bit 5) is set and both lines are released.
- R7: With high count H and low count L, SCL stays released for 2*(H+1) clock cycles and pulled low for 2*(L+1) cycles during every data bit inside a byte.
- R8: Writing to the clear register clears exactly the status flags (bits 6..0) whose bit is 1 and leaves the others. Writing back a status value just read clears all pending flags. A flag being set in the same cycle wins over its clear.
- R9: `irq` is high exactly when control bit 8 (enable), control bit 7 (global unmask) and at least one pending flag whose unmask bit in control bits 6..0 is set are all true. Those unmask bits use the same positions as the flags.
- R10: If SDA reads low at the end of a high phase while the master is releasing it for a data bit of a written byte, the arbitration flag (bit 1) is set. The command is abandoned without command-over, both lines are released, and busy stays set.
- R11: While control bit 8 is 0, commands are ignored: no bus activity and no flag changes.
- R12: START+WRITE+STOP (0x0B) in one write performs the start, the byte and the stop in that order. It ends with start, send, end and command-over set and busy clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index for reads and writes |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the register selected by `reg_idx` |
| irq | output | 1 | Masked interrupt request |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |

## Verification
The main path is exercised with a behavioural bus device that acknowledges or refuses written bytes and returns chosen bytes on reads. Written bytes are checked with the values 0xA4, 0x5A and 0x96, which catch a reversed or off-by-one bit order, and read bytes with 0x3C and 0xC5. The ACK and NACK cases are told apart by the level the device sees on the ninth clock. Separate cases cover commands chained with and without STOP, so that busy and the end flag are tied to the bus STOP rather than to command completion. A foreign pull on SDA during a written 1 must raise arbitration loss and no completion. A disabled controller must leave the bus untouched.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_idx,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             scl_in,
  input  logic             sda_in
);
  localparam logic [2:0] A_CTRL = 3'd0, A_CMD = 3'd1, A_CLR = 3'd2, A_STAT = 3'd3,
                         A_HCNT = 3'd4, A_LCNT = 3'd5, A_TXD = 3'd6, A_RXD = 3'd7;
  localparam logic [CNT_W:0] ONE = 1;

  typedef enum logic [3:0] {IDLE, ST_L, ST_H1, ST_H2, BIT_L, BIT_H, SP_L, SP_H1, SP_H2} st_t;

  st_t              state;
  logic [8:0]       ctrl;
  logic [6:0]       flags;
  logic [CNT_W-1:0] hcnt, lcnt;
  logic [CNT_W:0]   tmr;
  logic [7:0]       txd, rxd, sh;
  logic [3:0]       bc;
  logic             busy, hold, sda_r;
  logic             c_st, c_wr, c_rd, c_nack, c_sp;

  wire icr_we   = reg_we && reg_idx == A_CLR;
  wire cmd_go   = reg_we && reg_idx == A_CMD && ctrl[8] && state == IDLE && |reg_wdata[3:0];
  wire tmr_done = tmr == '0;
  wire [CNT_W:0] hload = {hcnt, 1'b1};
  wire [CNT_W:0] lload = {lcnt, 1'b1};
  wire [7:0] sh_nx = {sh[6:0], sda_in};
  wire c_byte = c_wr | c_rd;

  assign scl_oe = state == ST_L || state == BIT_L || state == SP_L || (state == IDLE && hold);
  assign sda_oe = sda_r;
  assign irq = ctrl[8] & ctrl[7] & |(flags & ctrl[6:0]);

  always_comb begin
    case (reg_idx)
      A_CTRL:  reg_rdata = CNT_W'(ctrl);
      A_STAT:  reg_rdata = CNT_W'({busy, flags});
      A_HCNT:  reg_rdata = hcnt;
      A_LCNT:  reg_rdata = lcnt;
      A_TXD:   reg_rdata = CNT_W'(txd);
      A_RXD:   reg_rdata = CNT_W'(rxd);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE; ctrl <= '0; flags <= '0; hcnt <= '0; lcnt <= '0; tmr <= '0;
      txd <= '0; rxd <= '0; sh <= '0; bc <= '0; busy <= 1'b0; hold <= 1'b0; sda_r <= 1'b0;
      c_st <= 1'b0; c_wr <= 1'b0; c_rd <= 1'b0; c_nack <= 1'b0; c_sp <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_idx)
          A_CTRL:  ctrl <= reg_wdata[8:0];
          A_HCNT:  hcnt <= reg_wdata;
          A_LCNT:  lcnt <= reg_wdata;
          A_TXD:   txd  <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (icr_we) flags <= flags & ~reg_wdata[6:0];
      if (state != IDLE && !tmr_done) tmr <= tmr - ONE;
      case (state)
        IDLE: if (cmd_go) begin
          c_st <= reg_wdata[3]; c_wr <= reg_wdata[1]; c_rd <= reg_wdata[2] & ~reg_wdata[1];
          c_nack <= reg_wdata[4]; c_sp <= reg_wdata[0]; bc <= '0; sh <= txd;
          if (reg_wdata[3]) begin
            state <= busy ? ST_L : ST_H1; tmr <= busy ? lload : hload; sda_r <= 1'b0;
          end else if (reg_wdata[2] | reg_wdata[1]) begin
            state <= BIT_L; tmr <= lload; sda_r <= reg_wdata[1] & ~txd[7];
          end else begin
            state <= SP_L; tmr <= lload; sda_r <= 1'b1;
          end
        end
        ST_L:  if (tmr_done) begin state <= ST_H1; tmr <= hload; end
        ST_H1: if (tmr_done) begin
          state <= ST_H2; tmr <= hload; sda_r <= 1'b1; busy <= 1'b1; flags[6] <= 1'b1;
        end
        ST_H2: if (tmr_done) begin
          if (c_byte) begin state <= BIT_L; tmr <= lload; sda_r <= c_wr & ~sh[7]; end
          else if (c_sp) begin state <= SP_L; tmr <= lload; sda_r <= 1'b1; end
          else begin state <= IDLE; hold <= busy; flags[0] <= 1'b1; end
        end
        BIT_L: if (tmr_done) begin state <= BIT_H; tmr <= hload; end
        BIT_H: if (tmr_done) begin
          if (bc != 4'd8) begin
            if (c_wr && !sda_r && !sda_in) begin
              state <= IDLE; sda_r <= 1'b0; hold <= 1'b0; flags[1] <= 1'b1;
            end else begin
              sh <= sh_nx; bc <= bc + 4'd1; state <= BIT_L; tmr <= lload;
              if (bc == 4'd7 && !c_wr) rxd <= sh_nx;
              if (bc == 4'd7) sda_r <= c_wr ? 1'b0 : ~c_nack;
              else sda_r <= c_wr & ~sh_nx[7];
            end
          end else begin
            if (c_wr) begin
              flags[4] <= 1'b1;
              if (sda_in) flags[2] <= 1'b1;
            end else flags[3] <= 1'b1;
            if (c_sp) begin state <= SP_L; tmr <= lload; sda_r <= 1'b1; end
            else begin state <= IDLE; hold <= busy; flags[0] <= 1'b1; end
          end
        end
        SP_L:  if (tmr_done) begin state <= SP_H1; tmr <= hload; end
        SP_H1: if (tmr_done) begin state <= SP_H2; tmr <= hload; sda_r <= 1'b0; end
        SP_H2: if (tmr_done) begin
          state <= IDLE; busy <= 1'b0; hold <= 1'b0; flags[5] <= 1'b1; flags[0] <= 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  wire unused_ok = &{1'b0, scl_in, c_st};
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [6:0] flags,
  input logic [8:0] ctrl,
  input logic       icr_we,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq,
  input logic       st_idle,
  input logic       in_st_hold,
  input logic       in_sp_rel,
  input logic       unused_ok
);
  AST_BUSY_ENDS_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> flags[5]); // R6
  AST_SDA_FALL_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && $rose(sda_oe)) |-> in_st_hold); // R2
  AST_SDA_RISE_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && $fell(sda_oe)) |-> in_sp_rel); // R6
  AST_ARB_WITHOUT_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> !$rose(flags[0])); // R10
  AST_FLAG_CLEARS_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> $past(icr_we)); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl[8] && ctrl[7]) |-> !irq); // R9
  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[8] && st_idle) |=> st_idle); // R11
  wire unused_chk = unused_ok;
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .flags(flags), .ctrl(ctrl), .icr_we(icr_we),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq), .st_idle(state == IDLE),
  .in_st_hold(state == ST_H2), .in_sp_rel(state == SP_H2), .unused_ok(unused_ok)
);

// File: tb/tb_i2c_cmd_master.sv
`timescale 1ns/1ps
module tb_i2c_cmd_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic reg_we = 1'b0;
  logic [2:0] reg_idx = 3'd0;
  logic [15:0] reg_wdata = '0;
  wire [15:0] reg_rdata;
  wire irq, scl_oe, sda_oe;
  logic force_low = 1'b0;

  logic s_active = 1'b0, s_tx = 1'b0, s_ack = 1'b1, s_mack = 1'b0;
  int s_idx = 0;
  logic [7:0] s_byte = '0, s_cap = '0, s_got = '0;
  wire s_drv = s_active && ((s_tx && s_idx >= 0 && s_idx < 8 && !s_byte[7 - s_idx]) ||
                            (!s_tx && s_idx == 8 && s_ack));
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || s_drv || force_low);

  i2c_cmd_master dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .scl_in(scl_w), .sda_in(sda_w));

  always @(negedge sda_w) if (scl_w) begin s_active = 1'b1; s_idx = -1; end
  always @(posedge sda_w) if (scl_w) s_active = 1'b0;
  always @(negedge scl_w) if (s_active) s_idx = (s_idx == 8) ? 0 : s_idx + 1;
  always @(posedge scl_w) if (s_active) begin
    if (s_idx >= 0 && s_idx < 8) s_cap = {s_cap[6:0], sda_w};
    else if (s_idx == 8) begin s_mack = sda_w; s_got = s_cap; end
  end

  int run = 0, hi_w = 0, lo_w = 0;
  logic scl_prev = 1'b1, saw_scl = 1'b0;
  always @(posedge clk) begin
    if (scl_oe) saw_scl = 1'b1;
    if (scl_w == scl_prev) run++;
    else begin
      if (s_active && s_idx >= 2 && s_idx <= 6) begin
        if (scl_prev) hi_w = run; else lo_w = run;
      end
      run = 1; scl_prev = scl_w;
    end
  end

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] idx, logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] idx, output logic [15:0] d);
    @(negedge clk); reg_idx = idx; #0.5; d = reg_rdata;
  endtask

  task automatic wait_stat(logic [15:0] mask);
    logic [15:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, v);
      if ((v & mask) != 0) return;
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(3'd3, v); check("R1 status", v, 16'h0);
    rd(3'd0, v); check("R1 control", v, 16'h0);
    check("R1 irq/lines", {13'd0, irq, scl_oe, sda_oe}, 16'h0);
  endtask

  task automatic t_disabled;
    logic [15:0] v;
    wr(3'd0, 16'h000); saw_scl = 1'b0;
    wr(3'd6, 16'hA4); wr(3'd1, 16'h0B);
    repeat (300) @(negedge clk);
    rd(3'd3, v); check("R11 status unchanged", v, 16'h0);
    check("R11 no bus activity", {15'd0, saw_scl}, 16'h0);
    wr(3'd0, 16'h1FF);
  endtask

  task automatic t_write_ack;
    logic [15:0] v;
    s_ack = 1'b1; s_tx = 1'b0;
    wr(3'd6, 16'hA4); wr(3'd1, 16'h0A); wait_stat(16'h1);
    rd(3'd3, v); check("R2 status after start+write", v, 16'hD1);
    check("R2 byte seen by device", {8'd0, s_got}, 16'hA4);
    check("R9 irq with pending unmasked", {15'd0, irq}, 16'h1);
    check("R7 SCL high width", 16'(hi_w), 16'd4);
    check("R7 SCL low width", 16'(lo_w), 16'd6);
  endtask

  task automatic t_w1c;
    logic [15:0] v;
    wr(3'd2, 16'h10); rd(3'd3, v); check("R8 clear one flag", v, 16'hC1);
    wr(3'd2, v); rd(3'd3, v); check("R8 write-back clears pending", v, 16'h80);
    check("R9 irq low when nothing pending", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_write_nack;
    logic [15:0] v;
    s_ack = 1'b0;
    wr(3'd6, 16'h5A); wr(3'd1, 16'h02); wait_stat(16'h1);
    rd(3'd3, v); check("R3 ack error and over", v, 16'h95);
    check("R3 byte seen by device", {8'd0, s_got}, 16'h5A);
    wr(3'd2, 16'h7F); s_ack = 1'b1;
  endtask

  task automatic t_read(logic [7:0] b, bit nack);
    logic [15:0] v;
    s_tx = 1'b1; s_byte = b;
    wr(3'd1, nack ? 16'h14 : 16'h04); wait_stat(16'h1);
    rd(3'd3, v); check(nack ? "R5 status" : "R4 status", v, 16'h89);
    rd(3'd7, v); check(nack ? "R5 receive byte" : "R4 receive byte", v, {8'd0, b});
    check(nack ? "R5 NACK level" : "R4 ACK level", {15'd0, s_mack}, {15'd0, nack});
    wr(3'd2, 16'h7F); s_tx = 1'b0;
  endtask

  task automatic t_stop;
    logic [15:0] v;
    wr(3'd1, 16'h01); wait_stat(16'h1);
    rd(3'd3, v); check("R6 busy clear, end set", v, 16'h21);
    check("R6 lines released, stop seen", {14'd0, scl_oe | sda_oe, s_active}, 16'h0);
    wr(3'd2, 16'h7F);
  endtask

  task automatic t_combined;
    logic [15:0] v;
    s_ack = 1'b1; s_got = 8'h00;
    wr(3'd6, 16'h96); wr(3'd1, 16'h0B); wait_stat(16'h1);
    rd(3'd3, v); check("R12 status", v, 16'h71);
    check("R12 byte between start and stop", {7'd0, s_active, s_got}, 16'h096);
  endtask

  task automatic t_irq_mask;
    wr(3'd0, 16'h1A0); check("R9 end unmasked", {15'd0, irq}, 16'h1);
    wr(3'd0, 16'h120); check("R9 global mask off", {15'd0, irq}, 16'h0);
    wr(3'd0, 16'h188); check("R9 only idle source unmasked", {15'd0, irq}, 16'h0);
    wr(3'd0, 16'h0FF); check("R9 controller disabled", {15'd0, irq}, 16'h0);
    wr(3'd0, 16'h1FF); wr(3'd2, 16'h7F);
  endtask

  task automatic t_arb;
    logic [15:0] v;
    wr(3'd1, 16'h08); wait_stat(16'h1);
    rd(3'd3, v); check("R6 start-only sets busy", v, 16'hC1);
    wr(3'd2, 16'h7F);
    force_low = 1'b1;
    wr(3'd6, 16'hFF); wr(3'd1, 16'h02); wait_stat(16'h3);
    repeat (20) @(negedge clk);
    rd(3'd3, v); check("R10 arbitration flag, no over", v, 16'h82);
    check("R10 lines released", {14'd0, scl_oe, sda_oe}, 16'h0);
    force_low = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    wr(3'd4, 16'd1); wr(3'd5, 16'd2);
    t_disabled();
    t_write_ack();
    t_w1c();
    t_write_nack();
    t_read(8'h3C, 1'b0);
    t_read(8'hC5, 1'b1);
    t_stop();
    t_combined();
    t_irq_mask();
    t_arb();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule